// File: doc/BRIEF.md
# Gated Bit-Timing Clock Generator

This block produces the bit timing for a slow asynchronous character link. It takes a fast oscillator tick, supplied as a one-cycle enable on the system clock, and divides it down to a long bit period. The divider is held cleared while the link is idle. A character gate opens it, runs it for a fixed number of bit periods and then closes it again.

A character is started by a transmit request, or in receive by the high-to-low transition on the line that marks a start bit. When the gate opens, a short divider-clear pulse is issued and the divider then counts ticks. Once per bit cell it raises a shift strobe lasting a few ticks. In transmit the strobe occupies the end of each bit cell. In receive it is taken from the opposite half of the cell, so it ends exactly at mid-bit, where the line is best sampled.

Top module: `bit_timing_gen`

## Requirements
- R1: While reset is asserted and whenever the gate is closed, `oscGate`, `divReset` and `shiftStrobe` are all low.
- R2: When the gate is closed and `txReq` is high at a clock edge, `oscGate` is high from that edge on and the character runs in transmit timing.
- R3: When the gate is closed and `txReq` is low, a high-to-low change of `lineIn` between two clock edges opens the gate at the second edge in receive timing. A line that merely stays low opens nothing.
- R4: `divReset` is high for exactly `RST_CLKS` clock cycles, starting in the cycle the gate rises. Ticks that arrive during that time are not counted, and `shiftStrobe` stays low.
- R5: After `divReset` falls, every `tickEn` pulse seen with the gate open advances the divider. A bit cell lasts 2^`DIV_LOG2` counted ticks.
- R6: In transmit, `shiftStrobe` is high while the count within the cell is in the last `STROBE_TICKS` positions of the cell.
- R7: In receive, `shiftStrobe` is high while the count within the cell lies in the `STROBE_TICKS` positions just below half the cell. It therefore falls when the count reaches mid-bit.
- R8: The gate closes at the clock edge that counts tick number `CHAR_BITS` × 2^`DIV_LOG2`. Exactly `CHAR_BITS` strobes are issued per character.
- R9: A transmit request or a falling line edge that arrives while the gate is open has no effect on the character timing.
- R10: If a transmit request and a falling line edge arrive in the same idle cycle, the character runs in transmit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oscillator tick, high for one clock per oscillator period |
| txReq | input | 1 | Transmit character request |
| lineIn | input | 1 | Serial line, idle high; a falling edge marks a start bit |
| oscGate | output | 1 | Character gate, high while the divider runs |
| divReset | output | 1 | Divider-clear pulse at gate opening |
| shiftStrobe | output | 1 | Shift strobe, once per bit cell |

## Verification
The bench builds the block with `DIV_LOG2`=4, `CHAR_BITS`=9, `STROBE_TICKS`=2 and `RST_CLKS`=3. Ticks arrive every third clock, so a whole character is about 450 cycles. Every strobe position, the mid-bit fall in receive and the closing edge can then be compared cycle by cycle against a tick count kept in the bench. The three-cycle clear pulse is long enough to swallow a tick, which exercises the rule that ticks are ignored during the clear.

// File: rtl/bitgen_pkg.sv
package bitgen_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dirMode_t;

  typedef struct packed {
    logic     clear;
    logic     advance;
    dirMode_t dir;
  } divCtrl_t;
endpackage

// File: rtl/bitgen_ctrl.sv
module bitgen_ctrl
  import bitgen_pkg::*;
#(
  parameter int RST_CLKS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     txReq,
  input  logic     lineIn,
  input  logic     charDone,
  output divCtrl_t ctrl,
  output logic     oscGate,
  output logic     divReset
);
  localparam int RW = (RST_CLKS < 2) ? 1 : $clog2(RST_CLKS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2
  } ctrlState_t;

  ctrlState_t state;
  logic [RW-1:0] clrLeft;
  logic linePrev;
  logic lineFell;
  dirMode_t dirQ;

  assign lineFell = linePrev & ~lineIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      clrLeft  <= '0;
      linePrev <= 1'b1;
      dirQ     <= DIR_TX;
    end else begin
      linePrev <= lineIn;
      unique case (state)
        ST_IDLE: begin
          if (txReq) begin
            state   <= ST_CLEAR;
            dirQ    <= DIR_TX;
            clrLeft <= RW'(RST_CLKS - 1);
          end else if (lineFell) begin
            state   <= ST_CLEAR;
            dirQ    <= DIR_RX;
            clrLeft <= RW'(RST_CLKS - 1);
          end
        end
        ST_CLEAR: begin
          if (clrLeft == '0) state <= ST_RUN;
          else clrLeft <= clrLeft - 1'b1;
        end
        ST_RUN: begin
          if (charDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign oscGate      = (state != ST_IDLE);
  assign divReset     = (state == ST_CLEAR);
  assign ctrl.clear   = (state != ST_RUN);
  assign ctrl.advance = (state == ST_RUN) && tickEn;
  assign ctrl.dir     = dirQ;
endmodule

// File: rtl/bitgen_div.sv
module bitgen_div
  import bitgen_pkg::*;
#(
  parameter int DIV_LOG2     = 7,
  parameter int CHAR_BITS    = 9,
  parameter int STROBE_TICKS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  divCtrl_t ctrl,
  output logic     charDone,
  output logic     shiftStrobe
);
  localparam int PERIOD = 1 << DIV_LOG2;
  localparam int HALF   = PERIOD / 2;
  localparam int BW     = (CHAR_BITS < 2) ? 1 : $clog2(CHAR_BITS);
  localparam logic [DIV_LOG2-1:0] PH_LAST = DIV_LOG2'(PERIOD - 1);
  localparam logic [BW-1:0]       BIT_LAST = BW'(CHAR_BITS - 1);

  logic [DIV_LOG2-1:0] phase;
  logic [BW-1:0]       bitIdx;
  logic                cellEnd;
  logic [1:0]          inWin;

  assign cellEnd  = ctrl.advance && (phase == PH_LAST);
  assign charDone = cellEnd && (bitIdx == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      phase  <= '0;
      bitIdx <= '0;
    end else if (ctrl.advance) begin
      phase <= phase + 1'b1;
      if (cellEnd) bitIdx <= bitIdx + 1'b1;
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_win
    localparam int LO = (d == 0) ? (PERIOD - STROBE_TICKS) : (HALF - STROBE_TICKS);
    localparam int HI = (d == 0) ? PERIOD : HALF;
    logic [DIV_LOG2:0] phWide;
    assign phWide   = {1'b0, phase};
    assign inWin[d] = (phWide >= (DIV_LOG2+1)'(LO)) && (phWide < (DIV_LOG2+1)'(HI));
  end

  assign shiftStrobe = !ctrl.clear && inWin[ctrl.dir];
endmodule

// File: rtl/bit_timing_gen.sv
module bit_timing_gen
  import bitgen_pkg::*;
#(
  parameter int DIV_LOG2     = 7,
  parameter int CHAR_BITS    = 9,
  parameter int STROBE_TICKS = 2,
  parameter int RST_CLKS     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic txReq,
  input  logic lineIn,
  output logic oscGate,
  output logic divReset,
  output logic shiftStrobe
);
  divCtrl_t ctrl;
  logic     charDone;

  bitgen_ctrl #(.RST_CLKS(RST_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txReq(txReq), .lineIn(lineIn),
    .charDone(charDone), .ctrl(ctrl), .oscGate(oscGate), .divReset(divReset)
  );

  bitgen_div #(
    .DIV_LOG2(DIV_LOG2), .CHAR_BITS(CHAR_BITS), .STROBE_TICKS(STROBE_TICKS)
  ) u_div (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .charDone(charDone), .shiftStrobe(shiftStrobe)
  );
endmodule

// File: rtl/bit_timing_gen_chk.sv
module bit_timing_gen_chk #(
  parameter int RST_CLKS = 2
) (
  input logic clk,
  input logic rstN,
  input logic txReq,
  input logic oscGate,
  input logic divReset,
  input logic shiftStrobe
);
  logic [15:0] clrLen;

  always_ff @(posedge clk) begin
    if (!rstN) clrLen <= '0;
    else if (divReset) clrLen <= clrLen + 1'b1;
    else clrLen <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !oscGate |-> (!divReset && !shiftStrobe));

  a_r2_tx_opens: assert property (@(posedge clk) disable iff (!rstN)
    (!oscGate && txReq) |=> oscGate);

  a_r4_clear_at_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscGate) |-> divReset);

  a_r4_clear_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divReset) |-> (clrLen == 16'(RST_CLKS)));

  a_r4_no_strobe_in_clear: assert property (@(posedge clk) disable iff (!rstN)
    divReset |-> !shiftStrobe);

  a_r9_gate_holds_in_clear: assert property (@(posedge clk) disable iff (!rstN)
    divReset |=> oscGate);
endmodule

bind bit_timing_gen bit_timing_gen_chk #(.RST_CLKS(RST_CLKS)) u_chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .oscGate(oscGate),
  .divReset(divReset), .shiftStrobe(shiftStrobe)
);

// File: tb/bit_timing_gen_bench.sv
module bit_timing_gen_bench;
  localparam int DIV_LOG2 = 4;
  localparam int CHAR_BITS = 9;
  localparam int STROBE_TICKS = 2;
  localparam int RST_CLKS = 3;
  localparam int TICK_EVERY = 3;
  localparam int PERIOD = 1 << DIV_LOG2;
  localparam int HALF = PERIOD / 2;
  localparam int TOTAL = CHAR_BITS * PERIOD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic txReq = 1'b0;
  logic lineIn = 1'b1;
  logic oscGate, divReset, shiftStrobe;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bit_timing_gen #(
    .DIV_LOG2(DIV_LOG2), .CHAR_BITS(CHAR_BITS),
    .STROBE_TICKS(STROBE_TICKS), .RST_CLKS(RST_CLKS)
  ) u_bit_timing_gen (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txReq(txReq), .lineIn(lineIn),
    .oscGate(oscGate), .divReset(divReset), .shiftStrobe(shiftStrobe)
  );

  initial begin
    int phaseCnt = 0;
    forever begin
      @(posedge clk);
      #2;
      tickEn = (phaseCnt == 0);
      phaseCnt = (phaseCnt + 1) % TICK_EVERY;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(oscGate, 1'b0, "R1", "gate in reset");
    chk(divReset, 1'b0, "R1", "divReset in reset");
    chk(shiftStrobe, 1'b0, "R1", "strobe in reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(oscGate, 1'b0, "R1", "gate idle after reset");
  endtask

  // Runs one character and compares every cycle with a tick-count model.
  task automatic run_char(input bit doTx, input bit doRx, input bit expRx,
                          input int injectAt, input bit keepLow, input string req);
    int cnt = 0;
    int k = 0;
    int rises = 0;
    int ph;
    bit lastS = 0;
    bit pTick, pG, pR, expG, expR, win, expS;
    @(negedge clk);
    if (doTx) txReq = 1'b1;
    if (doRx) lineIn = 1'b0;
    pTick = tickEn; pG = 0; pR = 0;
    while (k < 4 * TOTAL * TICK_EVERY) begin
      @(negedge clk);
      if (pTick && pG && !pR) cnt++;
      expG = (cnt < TOTAL);
      expR = expG && (k < RST_CLKS);
      ph = cnt % PERIOD;
      win = expRx ? (ph >= HALF - STROBE_TICKS && ph < HALF) : (ph >= PERIOD - STROBE_TICKS);
      expS = expG && !expR && win;
      chk(oscGate, expG, (k == 0) ? (expRx ? "R3" : "R2") : "R8", "gate");
      chk(divReset, expR, "R4", "divReset");
      chk(shiftStrobe, expS, expRx ? "R7" : "R6", "strobe");
      if (shiftStrobe && !lastS) rises++;
      lastS = shiftStrobe;
      k++;
      pTick = tickEn; pG = expG; pR = expR;
      if (k == 1) begin
        txReq = 1'b0;
        if (!keepLow) lineIn = 1'b1;
      end
      if (k == injectAt) begin txReq = 1'b1; lineIn = 1'b0; end
      if (k == injectAt + 2) begin txReq = 1'b0; lineIn = 1'b1; end
      if (!expG) break;
    end
    vectors++;
    if (rises != CHAR_BITS) begin
      fails++;
      $display("FAIL R8 %s strobe count: actual %0d expected %0d", req, rises, CHAR_BITS);
    end
    repeat (20) begin
      @(negedge clk);
      chk(oscGate, 1'b0, req, "stays closed after character");
    end
  endtask

  initial begin
    test_reset();
    run_char(1, 0, 0, 0, 0, "R2");        // transmit character, R5 R6
    run_char(0, 1, 1, 0, 0, "R3");        // receive character, R5 R7
    run_char(1, 0, 0, 200, 0, "R9");      // restart attempt mid-character
    run_char(0, 1, 1, 150, 0, "R9");      // line edge mid-receive
    run_char(1, 1, 0, 0, 0, "R10");       // both starts together
    run_char(0, 1, 1, 0, 1, "R3");        // line held low: no second start
    lineIn = 1'b1;
    repeat (5) @(negedge clk);
    chk(oscGate, 1'b0, "R3", "idle after line returns high");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule